// File: doc/BRIEF.md
# Display Power and Initialization Sequencer

This block drives the supply enables and the reset line of a 128×32 passive-matrix OLED panel controller and produces every command byte the controller needs across its life: bring-up, sleep, wake, recovery re-initialization and shutdown. The bytes leave through a valid/ready stream toward a separate byte writer. Each byte carries a flag that marks it as a command byte or as a display-data byte.

The host gives single-cycle request pulses. Every wait is counted in periods of an external `tick` strobe, so the block can run from any clock. During bring-up, the high-voltage panel supply is switched on only after the controller is configured and its screen memory has been written dark. It then settles for a programmed window before the display is enabled. The logic supply is always removed last. `busy` covers each running sequence, and `done` marks the end of each sequence with a one-cycle pulse.

Top module: `disp_pwr_seq`

## Requirements
- R1: While `rst_n` is low, and after reset, the outputs `logic_en`, `panel_en`, `disp_rst_n`, `out_valid`, `busy` and `done` are all 0.
- R2: A power-up request received while fully off raises `logic_en` and holds `disp_rst_n` low for exactly `RST_LOW_TICKS` ticks. `disp_rst_n` then stays high for exactly `RST_REL_TICKS` ticks before the first byte is offered. No byte is ever offered while `disp_rst_n` is low.
- R3: The configuration list is sent in this order, all with `out_is_data`=0: AE, D5 F0, 81 80, D9 C2, A8 1F, D3 00, 40, A6, A1, C8, DA 12, D8 05, DB 08, A4 (22 bytes; the first byte is the display-off command).
- R4: `CLEAR_BYTES` bytes of value 00 with `out_is_data`=1 follow the list. `panel_en` is 0 while they are sent.
- R5: `panel_en` rises only after the last clear byte has been accepted. After exactly `SETTLE_TICKS` ticks, the display-on command AF (`out_is_data`=0) is offered, and this happens only while `panel_en` is 1.
- R6: A byte is transferred on a clock edge where `out_valid` and `out_ready` are both 1. While `out_ready` is low, `out_valid`, `out_byte` and `out_is_data` hold their values.
- R7: A power-down request while the display is on sends AE. `panel_en` then drops, the block waits `SETTLE_TICKS` ticks with only the logic supply on, and then `logic_en` drops.
- R8: A sleep request while the display is on sends AE and then drops `panel_en`, while `logic_en` stays 1. A wake request while asleep raises `panel_en`, sends no byte for `SETTLE_TICKS` ticks, and then sends AF.
- R9: `logic_en` never falls in a cycle where `panel_en` was 1. A power-down from sleep waits `SETTLE_TICKS` ticks and then drops `logic_en`.
- R10: Each request is accepted only in its own resting state: up when off; down, sleep and re-init when on; wake and down when asleep. All other requests are ignored. `busy` is 1 for the whole of a sequence. `done` is a one-cycle pulse at its end, with `busy` at 0.
- R11: A re-init request while the display is on drops `panel_en` and drives `disp_rst_n` low for `RST_LOW_TICKS` ticks. It then replays the whole bring-up from R2 to R5: list, clear, panel settle and AF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase strobe; all waits count its high cycles |
| req_up | input | 1 | Power-up request pulse |
| req_down | input | 1 | Power-down request pulse |
| req_sleep | input | 1 | Sleep request pulse |
| req_wake | input | 1 | Wake request pulse |
| req_reinit | input | 1 | Recovery re-initialization request pulse |
| out_ready | input | 1 | Byte writer can take a byte |
| logic_en | output | 1 | Logic supply enable |
| panel_en | output | 1 | Panel high-voltage supply enable |
| disp_rst_n | output | 1 | Controller reset, active low |
| out_valid | output | 1 | A byte is offered |
| out_is_data | output | 1 | 1 = display data byte, 0 = command byte |
| out_byte | output | 8 | Offered byte |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse when a sequence completes |

## Verification
Two things are hard to reach from the ports. The first is a stalled transfer at every kind of byte: list byte, clear byte, and the lone AE or AF of a short sequence. The second is a request that lands in the middle of a wait window. The bench runs the tick strobe and the ready stall on co-prime periods of 3 and 5 cycles, so stalls fall on many different byte positions and waits start at varying tick phases. It also fires foreign requests in the middle of a bring-up and while resting in the wrong state. Every window length is counted in ticks at the ports and compared with the parameter.

// File: rtl/disp_pwr_seq.sv
module disp_pwr_seq #(
  parameter int SETTLE_TICKS  = 100000,
  parameter int RST_LOW_TICKS = 10,
  parameter int RST_REL_TICKS = 3,
  parameter int CLEAR_BYTES   = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       req_up,
  input  logic       req_down,
  input  logic       req_sleep,
  input  logic       req_wake,
  input  logic       req_reinit,
  input  logic       out_ready,
  output logic       logic_en,
  output logic       panel_en,
  output logic       disp_rst_n,
  output logic       out_valid,
  output logic       out_is_data,
  output logic [7:0] out_byte,
  output logic       busy,
  output logic       done
);
  localparam int LIST_LEN = 22;
  localparam int M0 = (SETTLE_TICKS > RST_LOW_TICKS) ? SETTLE_TICKS : RST_LOW_TICKS;
  localparam int M1 = (M0 > RST_REL_TICKS) ? M0 : RST_REL_TICKS;
  localparam int M2 = (M1 > CLEAR_BYTES) ? M1 : CLEAR_BYTES;
  localparam int MAXC = (M2 > LIST_LEN) ? M2 : LIST_LEN;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [3:0] {
    S_OFF, S_RLO, S_RHI, S_INIT, S_CLR, S_PWAIT, S_ON, S_ACT,
    S_DOFF, S_DWAIT, S_SOFF, S_SLEEP, S_WWAIT
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt, lim;
  logic          hit, xfer;

  function automatic logic [7:0] init_byte(input int i);
    case (i)
      0: return 8'hAE;  1: return 8'hD5;  2: return 8'hF0;  3: return 8'h81;
      4: return 8'h80;  5: return 8'hD9;  6: return 8'hC2;  7: return 8'hA8;
      8: return 8'h1F;  9: return 8'hD3; 10: return 8'h00; 11: return 8'h40;
     12: return 8'hA6; 13: return 8'hA1; 14: return 8'hC8; 15: return 8'hDA;
     16: return 8'h12; 17: return 8'hD8; 18: return 8'h05; 19: return 8'hDB;
     20: return 8'h08;
      default: return 8'hA4;
    endcase
  endfunction

  always_comb begin
    case (state)
      S_RLO:                    lim = CW'(RST_LOW_TICKS);
      S_RHI:                    lim = CW'(RST_REL_TICKS);
      S_INIT:                   lim = CW'(LIST_LEN);
      S_CLR:                    lim = CW'(CLEAR_BYTES);
      default:                  lim = CW'(SETTLE_TICKS);
    endcase
  end

  assign hit  = (cnt == lim - 1'b1);
  assign xfer = out_valid && out_ready;

  assign logic_en    = (state != S_OFF);
  assign disp_rst_n  = !(state inside {S_OFF, S_RLO});
  assign panel_en    = state inside {S_PWAIT, S_ON, S_ACT, S_DOFF, S_SOFF, S_WWAIT};
  assign out_valid   = state inside {S_INIT, S_CLR, S_ON, S_DOFF, S_SOFF};
  assign out_is_data = (state == S_CLR);
  assign out_byte    = (state == S_INIT) ? init_byte(int'(cnt)) :
                       (state == S_CLR)  ? 8'h00 :
                       (state == S_ON)   ? 8'hAF : 8'hAE;
  assign busy        = !(state inside {S_OFF, S_ACT, S_SLEEP});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OFF;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_OFF: if (req_up) begin state <= S_RLO; cnt <= '0; end
        S_RLO, S_RHI, S_PWAIT, S_DWAIT, S_WWAIT:
          if (tick) begin
            if (hit) begin
              cnt <= '0;
              case (state)
                S_RLO:   state <= S_RHI;
                S_RHI:   state <= S_INIT;
                S_DWAIT: begin state <= S_OFF; done <= 1'b1; end
                default: state <= S_ON;
              endcase
            end else cnt <= cnt + 1'b1;
          end
        S_INIT, S_CLR:
          if (xfer) begin
            if (hit) begin
              cnt   <= '0;
              state <= (state == S_INIT) ? S_CLR : S_PWAIT;
            end else cnt <= cnt + 1'b1;
          end
        S_ON:   if (xfer) begin state <= S_ACT; done <= 1'b1; end
        S_ACT: begin
          cnt <= '0;
          if (req_down)        state <= S_DOFF;
          else if (req_sleep)  state <= S_SOFF;
          else if (req_reinit) state <= S_RLO;
        end
        S_DOFF: if (xfer) begin state <= S_DWAIT; cnt <= '0; end
        S_SOFF: if (xfer) begin state <= S_SLEEP; done <= 1'b1; end
        S_SLEEP: begin
          cnt <= '0;
          if (req_down)      state <= S_DWAIT;
          else if (req_wake) state <= S_WWAIT;
        end
        default: state <= S_OFF;
      endcase
    end
  end

  p_panel_needs_logic_r9: assert property (@(posedge clk) disable iff (!rst_n)
    panel_en |-> logic_en);
  p_logic_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(logic_en) |-> !$past(panel_en));
  p_hold_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_byte) && $stable(out_is_data));
  p_no_byte_in_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> disp_rst_n);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_on_cmd_panel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_is_data && out_byte == 8'hAF |-> panel_en);
  p_clear_dark_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_is_data |-> !panel_en && out_byte == 8'h00);
endmodule

// File: tb/disp_pwr_seq_test.sv
module disp_pwr_seq_test;
  localparam int ST = 5, RL = 3, RR = 2, CB = 8, LL = 22;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, out_ready = 1'b0;
  logic req_up = 0, req_down = 0, req_sleep = 0, req_wake = 0, req_reinit = 0;
  logic logic_en, panel_en, disp_rst_n, out_valid, out_is_data, busy, done;
  logic [7:0] out_byte;

  disp_pwr_seq #(.SETTLE_TICKS(ST), .RST_LOW_TICKS(RL), .RST_REL_TICKS(RR), .CLEAR_BYTES(CB)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .req_up(req_up), .req_down(req_down),
    .req_sleep(req_sleep), .req_wake(req_wake), .req_reinit(req_reinit), .out_ready(out_ready),
    .logic_en(logic_en), .panel_en(panel_en), .disp_rst_n(disp_rst_n), .out_valid(out_valid),
    .out_is_data(out_is_data), .out_byte(out_byte), .busy(busy), .done(done));

  int errs = 0, checks = 0, cyc = 0;
  int nlog, n_rlo, n_quiet, n_pquiet, n_busy, ndone, rise_at, fall_at;
  int bad_order = 0, hold_bad = 0, stalls = 0;
  logic [7:0] log_b [0:63];
  logic       log_d [0:63];
  logic pp = 0, pl = 0, hold_pend = 0, hd = 0;
  logic [7:0] hb = 0;

  function automatic logic [7:0] exp_list(input int i);
    logic [7:0] t [0:21] = '{8'hAE, 8'hD5, 8'hF0, 8'h81, 8'h80, 8'hD9, 8'hC2, 8'hA8, 8'h1F,
      8'hD3, 8'h00, 8'h40, 8'hA6, 8'hA1, 8'hC8, 8'hDA, 8'h12, 8'hD8, 8'h05, 8'hDB, 8'h08, 8'hA4};
    return t[i];
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tick = (cyc % 3 == 0);
    out_ready = (cyc % 5 != 2);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (panel_en && !pp) rise_at = nlog;
      if (!panel_en && pp) fall_at = nlog;
      if (!logic_en && pl && pp) bad_order++;
      if (tick && logic_en && !disp_rst_n) n_rlo++;
      if (tick && busy && logic_en && disp_rst_n && !panel_en && !out_valid) n_quiet++;
      if (tick && busy && panel_en && !out_valid) n_pquiet++;
      if (busy) n_busy++;
      if (done) ndone++;
      if (hold_pend && !(out_valid && out_byte == hb && out_is_data == hd)) hold_bad++;
      hold_pend = out_valid && !out_ready;
      if (hold_pend) stalls++;
      hb = out_byte; hd = out_is_data;
      if (out_valid && out_ready) begin
        if (nlog < 64) begin log_b[nlog] = out_byte; log_d[nlog] = out_is_data; end
        nlog++;
      end
      pp = panel_en; pl = logic_en;
    end
  end

  task automatic clear_mon();
    nlog = 0; n_rlo = 0; n_quiet = 0; n_pquiet = 0; n_busy = 0; ndone = 0;
    rise_at = -1; fall_at = -1;
  endtask

  task automatic pulse(input int w);
    @(negedge clk);
    req_up = (w == 0); req_down = (w == 1); req_sleep = (w == 2);
    req_wake = (w == 3); req_reinit = (w == 4);
    @(negedge clk);
    req_up = 0; req_down = 0; req_sleep = 0; req_wake = 0; req_reinit = 0;
  endtask

  task automatic wait_done(input string r);
    int n = 0;
    while (ndone == 0 && n < 5000) begin @(negedge clk); n++; end
    chk({r, " sequence completes"}, int'(ndone > 0), 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_bringup(input string r);
    int ml = 0, mc = 0;
    chk({r, " byte count"}, nlog, LL + CB + 1);
    for (int i = 0; i < LL; i++) if (log_b[i] != exp_list(i) || log_d[i] != 1'b0) ml++;
    chk({r, " R3 list order and command flag"}, ml, 0);
    for (int i = LL; i < LL + CB; i++) if (log_b[i] != 8'h00 || log_d[i] != 1'b1) mc++;
    chk({r, " R4 clear bytes"}, mc, 0);
    chk({r, " R5 final AF"}, {23'd0, log_d[LL + CB], log_b[LL + CB]}, 32'h0AF);
    chk({r, " R5 panel rises after clear"}, rise_at, LL + CB);
    chk({r, " R5 settle ticks"}, n_pquiet, ST);
    chk({r, " R2 reset-low ticks"}, n_rlo, RL);
    chk({r, " R2 release ticks"}, n_quiet, RR);
    chk({r, " R10 single done"}, ndone, 1);
  endtask

  initial begin
    #(200000 * 20);
    errs++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    clear_mon();
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {logic_en, panel_en, disp_rst_n, out_valid, busy, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1 after reset", {logic_en, panel_en, disp_rst_n, out_valid, busy, done}, 0);

    clear_mon();
    pulse(0);
    repeat (8) @(negedge clk);
    pulse(1); pulse(2);
    wait_done("R2 up");
    check_bringup("R2 up");
    chk("R10 busy during bring-up", int'(n_busy > 0), 1);
    chk("R10 mid-sequence requests ignored, on", {logic_en, panel_en, busy}, 3'b110);

    clear_mon();
    pulse(2);
    wait_done("R8 sleep");
    chk("R8 sleep bytes", nlog, 1);
    chk("R8 sleep AE", {log_d[0], log_b[0]}, 9'h0AE);
    chk("R8 panel off after AE", fall_at, 1);
    chk("R8 logic stays on", {logic_en, panel_en}, 2'b10);

    clear_mon();
    pulse(4); pulse(0); pulse(2);
    repeat (20) @(negedge clk);
    chk("R10 asleep ignores foreign requests", nlog + n_busy, 0);
    chk("R10 asleep state kept", {logic_en, panel_en, disp_rst_n}, 3'b101);

    clear_mon();
    pulse(3);
    wait_done("R8 wake");
    chk("R8 panel up before any byte", rise_at, 0);
    chk("R8 wake settle ticks", n_pquiet, ST);
    chk("R8 wake AF", {nlog, 23'd0, log_d[0], log_b[0]}, {32'd1, 32'h0AF});

    clear_mon();
    pulse(4);
    wait_done("R11 reinit");
    chk("R11 panel drops first", fall_at, 0);
    check_bringup("R11 reinit");

    clear_mon();
    pulse(1);
    wait_done("R7 down");
    chk("R7 down AE", {nlog, 23'd0, log_d[0], log_b[0]}, {32'd1, 32'h0AE});
    chk("R7 panel off after AE", fall_at, 1);
    chk("R7 logic-only wait ticks", n_quiet, ST);
    chk("R7 all off", {logic_en, panel_en, disp_rst_n}, 0);

    clear_mon();
    pulse(1); pulse(2); pulse(3); pulse(4);
    repeat (20) @(negedge clk);
    chk("R10 off ignores foreign requests", n_busy + int'(logic_en), 0);

    clear_mon(); pulse(0); wait_done("R9 up");
    clear_mon(); pulse(2); wait_done("R9 sleep");
    clear_mon();
    pulse(1);
    wait_done("R9 down from sleep");
    chk("R9 no bytes from sleep", nlog, 0);
    chk("R9 wait ticks from sleep", n_quiet, ST);
    chk("R9 logic off", int'(logic_en), 0);
    chk("R9 logic never dropped with panel on", bad_order, 0);

    chk("R6 stalls seen", int'(stalls > 10), 1);
    chk("R6 stalled byte held", hold_bad, 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule